// File: doc/BRIEF.md
# Per-Bit Attribute Control Register

A single bus-visible register whose bits each follow an access rule fixed at elaboration time. Constant masks mark each bit as read-only, write-one-to-clear, reserved, or clear-on-read. Any bit not marked read-only, write-one-to-clear or reserved is an ordinary read-write bit. A further mask gives the value loaded at reset. The bus side is a read strobe, a write strobe, write data and a byte-lane enable that applies to both reads and writes. The hardware side has a per-bit set input for status events and a view of the stored word.

A read returns the stored word one cycle later, masked to the enabled lanes, with reserved bits forced to zero. Clear-on-read bits are then cleared, but only inside the lanes that the read enabled. A completed write raises a one-cycle done pulse, which carries the masked result of the access, so that follow-up logic can act on it.

A small access tracker records which access completed at the last edge. Its states are `ACC_IDLE` (no access), `ACC_READ` (read only), `ACC_WRITE` (write only) and `ACC_BOTH` (read and write together). From any state, the next state is chosen by the strobe pair sampled at the edge:
- neither strobe gives `ACC_IDLE`
- the read strobe alone gives `ACC_READ`
- the write strobe alone gives `ACC_WRITE`
- both strobes give `ACC_BOTH`

Reset returns the tracker to `ACC_IDLE`. The read-valid output is high in `ACC_READ` and `ACC_BOTH`. The write-done output is high in `ACC_WRITE` and `ACC_BOTH`.

Top module: `attr_ctrl_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the stored word (`hw_value`) loads `RESET_VAL`, and on the next cycle `rd_valid` and `wr_done` are low.
- R2: A bus write never changes a bit in `RO_MASK`. Such a bit changes only through `hw_set`, or by a read clear if it is also in `COR_MASK`.
- R3: A bit in `W1C_MASK` within an enabled write lane is cleared when its write data bit is 1, and is unchanged when its write data bit is 0.
- R4: Bits in `RSVD_MASK` keep their reset value whatever the writes, reads or `hw_set` do. They always read as 0 in `rd_data` and in `wr_value`.
- R5: An ordinary read-write bit takes its write data bit only when its byte lane is enabled. Lane k covers bits 8k to 8k+7 and is enabled by `lane_en[k]`.
- R6: One cycle after `rd_en` is sampled high, `rd_valid` is high and `rd_data` equals the stored word before the access, ANDed with the enabled-lane mask, with reserved bits zero. Otherwise `rd_valid` and `rd_data` are 0.
- R7: After a read, the bits in `COR_MASK` inside the enabled read lanes are 0. Bits in `COR_MASK` outside those lanes keep their value.
- R8: A bit whose `hw_set` input is 1 at an edge holds 1 after that edge. This overrides write-one-to-clear, clear-on-read and a written 0.
- R9: When reads and writes occur in the same cycle, the read returns the value from before the access, and both effects are then applied. For a clear-on-read bit that is written in an enabled lane, the written value wins.
- R10: One cycle after `wr_en` is sampled high, `wr_done` is high for one cycle and `wr_value` equals the stored word after the access, ANDed with the enabled-lane mask, with reserved bits zero. Otherwise `wr_value` is 0.
- R11: In a cycle with no strobe and no `hw_set` bit, the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| lane_en | input | DATA_W/LANE_W | Byte-lane enable for reads and writes |
| wdata | input | DATA_W | Write data |
| hw_set | input | DATA_W | Per-bit hardware set, wins over any clear |
| rd_data | output | DATA_W | Masked read result, valid with rd_valid |
| rd_valid | output | 1 | Read result present (one cycle after rd_en) |
| wr_done | output | 1 | Write completed pulse (one cycle after wr_en) |
| wr_value | output | DATA_W | Masked post-write value, valid with wr_done |
| hw_value | output | DATA_W | Stored word for hardware use |

## Verification
Every result of an access is due exactly one edge after the access is sampled:
- `rd_valid` and `rd_data` show the word from before the access.
- `wr_done` and `wr_value` show the word after the access.
- `hw_value` shows the new stored word.

The bench drives each access at a falling edge and lets one rising edge pass. It compares all five outputs at the next falling edge against a bit-by-bit model advanced once per access, and drives the following access at that same falling edge. This makes back-to-back accesses legal and checked. The sweep covers all lane-enable values and all four strobe combinations, across several data patterns, with and without hardware set events.

// File: rtl/attr_reg_pkg.sv
package attr_reg_pkg;

    // Which access completed at the most recent clock edge.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_BOTH  = 2'd3
    } acc_state_e;

    // Bus strobe pair, packed as {read, write}.
    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    function automatic acc_state_e state_for(input strobe_t s);
        acc_state_e r;
        unique case ({s.rd, s.wr})
            2'b00:   r = ACC_IDLE;
            2'b10:   r = ACC_READ;
            2'b01:   r = ACC_WRITE;
            default: r = ACC_BOTH;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lane_mask_gen.sv
// Expands a per-lane enable into a per-bit mask, gated by an access strobe.
module lane_mask_gen #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W
) (
    input  logic              strobe,
    input  logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] bit_mask
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign bit_mask[k*LANE_W +: LANE_W] = {LANE_W{strobe & lane_en[k]}};
    end

endmodule

// File: rtl/attr_next_calc.sv
// Computes the next stored word from the current word and this cycle's events.
module attr_next_calc #(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] RO_MASK   = '0,
    parameter logic [DATA_W-1:0] W1C_MASK  = '0,
    parameter logic [DATA_W-1:0] RSVD_MASK = '0,
    parameter logic [DATA_W-1:0] COR_MASK  = '0
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wsel,     // enabled write lanes, already gated by wr_en
    input  logic [DATA_W-1:0] rsel,     // enabled read lanes, already gated by rd_en
    input  logic [DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0] nxt
);

    // Effective classes, with priority reserved > read-only > write-1-clear > read-write.
    localparam logic [DATA_W-1:0] LIVE    = ~RSVD_MASK;
    localparam logic [DATA_W-1:0] RO_EFF  = RO_MASK & LIVE;
    localparam logic [DATA_W-1:0] W1C_EFF = W1C_MASK & ~RO_MASK & LIVE;
    localparam logic [DATA_W-1:0] RW_EFF  = LIVE & ~RO_MASK & ~W1C_MASK;
    localparam logic [DATA_W-1:0] COR_EFF = COR_MASK & LIVE;

    logic [DATA_W-1:0] read_clr;
    logic [DATA_W-1:0] after_read;
    logic [DATA_W-1:0] ro_part;
    logic [DATA_W-1:0] w1c_part;
    logic [DATA_W-1:0] rw_part;
    logic [DATA_W-1:0] sw_result;

    always_comb begin
        // Read-side clear first; a write in the same cycle is applied on top of it.
        read_clr   = COR_EFF & rsel;
        after_read = cur & ~read_clr;

        ro_part    = RO_EFF  & after_read;
        w1c_part   = W1C_EFF & after_read & ~(wsel & wdata);
        rw_part    = RW_EFF  & ((wsel & wdata) | (~wsel & after_read));
        sw_result  = ro_part | w1c_part | rw_part;

        // Hardware set wins on live bits; reserved bits hold.
        nxt = (cur & RSVD_MASK) | (LIVE & (sw_result | hw_set));
    end

endmodule

// File: rtl/acc_fsm.sv
// Tracks the access completed at the last edge and drives the completion flags.
module acc_fsm
    import attr_reg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_en,
    input  logic wr_en,
    output logic rd_valid,
    output logic wr_done
);

    acc_state_e state_q;
    acc_state_e state_d;
    strobe_t    strobes;

    assign strobes = '{rd: rd_en, wr: wr_en};

    always_comb begin
        state_d = state_for(strobes);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ACC_IDLE:  begin rd_valid = 1'b0; wr_done = 1'b0; end
            ACC_READ:  begin rd_valid = 1'b1; wr_done = 1'b0; end
            ACC_WRITE: begin rd_valid = 1'b0; wr_done = 1'b1; end
            ACC_BOTH:  begin rd_valid = 1'b1; wr_done = 1'b1; end
            default:   begin rd_valid = 1'b0; wr_done = 1'b0; end
        endcase
    end

endmodule

// File: rtl/attr_ctrl_reg.sv
// Single register with per-bit access attributes.
module attr_ctrl_reg #(
    parameter int                DATA_W    = 32,
    parameter int                LANE_W    = 8,
    parameter logic [DATA_W-1:0] RO_MASK   = 32'h0000_00F0,
    parameter logic [DATA_W-1:0] W1C_MASK  = 32'h0000_FF00,
    parameter logic [DATA_W-1:0] RSVD_MASK = 32'hFF00_0000,
    parameter logic [DATA_W-1:0] COR_MASK  = 32'h00F0_0000,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_0005
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_en,
    input  logic                       wr_en,
    input  logic [DATA_W/LANE_W-1:0]   lane_en,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W-1:0]          hw_set,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic                       wr_done,
    output logic [DATA_W-1:0]          wr_value,
    output logic [DATA_W-1:0]          hw_value
);

    localparam int                LANES    = DATA_W / LANE_W;
    localparam logic [DATA_W-1:0] VISIBLE  = ~RSVD_MASK;

    logic [DATA_W-1:0] stored_q;
    logic [DATA_W-1:0] stored_d;
    logic [DATA_W-1:0] rsel;
    logic [DATA_W-1:0] wsel;
    logic [DATA_W-1:0] rd_cap_q;
    logic [DATA_W-1:0] wr_cap_q;

    lane_mask_gen #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES)) u_rd_lanes (
        .strobe   (rd_en),
        .lane_en  (lane_en),
        .bit_mask (rsel)
    );

    lane_mask_gen #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES)) u_wr_lanes (
        .strobe   (wr_en),
        .lane_en  (lane_en),
        .bit_mask (wsel)
    );

    attr_next_calc #(
        .DATA_W    (DATA_W),
        .RO_MASK   (RO_MASK),
        .W1C_MASK  (W1C_MASK),
        .RSVD_MASK (RSVD_MASK),
        .COR_MASK  (COR_MASK)
    ) u_next (
        .cur    (stored_q),
        .wdata  (wdata),
        .wsel   (wsel),
        .rsel   (rsel),
        .hw_set (hw_set),
        .nxt    (stored_d)
    );

    acc_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .rd_valid (rd_valid),
        .wr_done  (wr_done)
    );

    // Stored word and access captures.
    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= RESET_VAL;
            rd_cap_q <= '0;
            wr_cap_q <= '0;
        end else begin
            stored_q <= stored_d;
            if (rd_en) begin
                rd_cap_q <= stored_q & rsel & VISIBLE;
            end
            if (wr_en) begin
                wr_cap_q <= stored_d & wsel & VISIBLE;
            end
        end
    end

    // Output data, qualified by the tracker flags.
    always_comb begin
        rd_data  = rd_valid ? rd_cap_q : '0;
        wr_value = wr_done  ? wr_cap_q : '0;
        hw_value = stored_q;
    end

endmodule

// File: rtl/attr_ctrl_reg_chk.sv
module attr_ctrl_reg_chk #(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] RO_MASK   = '0,
    parameter logic [DATA_W-1:0] RSVD_MASK = '0,
    parameter logic [DATA_W-1:0] COR_MASK  = '0,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] hw_set,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              wr_done,
    input logic [DATA_W-1:0] wr_value,
    input logic [DATA_W-1:0] hw_value
);

    localparam logic [DATA_W-1:0] RO_FIXED = RO_MASK & ~COR_MASK & ~RSVD_MASK;
    localparam logic [DATA_W-1:0] LIVE     = ~RSVD_MASK;

    // R1
    reset_load_chk: assert property (@(posedge clk)
        rst |=> (hw_value == RESET_VAL) && !rd_valid && !wr_done);

    // R4
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_value & RSVD_MASK) == (RESET_VAL & RSVD_MASK));

    // R4
    rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ((rd_data & RSVD_MASK) == '0) && ((wr_value & RSVD_MASK) == '0));

    // R6
    read_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R6
    read_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid && (rd_data == '0));

    // R10
    write_done_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> wr_done);

    // R10
    write_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !wr_done && (wr_value == '0));

    // R2
    ro_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ((hw_set & RO_FIXED) == '0) |=> ((hw_value & RO_FIXED) == ($past(hw_value) & RO_FIXED)));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|(hw_set & LIVE)) |=> ((hw_value & $past(hw_set) & LIVE) == ($past(hw_set) & LIVE)));

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en && (hw_set == '0)) |=> $stable(hw_value));

endmodule

bind attr_ctrl_reg attr_ctrl_reg_chk #(
    .DATA_W    (DATA_W),
    .RO_MASK   (RO_MASK),
    .RSVD_MASK (RSVD_MASK),
    .COR_MASK  (COR_MASK),
    .RESET_VAL (RESET_VAL)
) u_attr_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .hw_set   (hw_set),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .wr_done  (wr_done),
    .wr_value (wr_value),
    .hw_value (hw_value)
);

// File: tb/tb_attr_ctrl_reg.sv
module tb_attr_ctrl_reg;

    localparam logic [15:0] P_RO   = 16'h1111;
    localparam logic [15:0] P_W1C  = 16'h2222;
    localparam logic [15:0] P_RSVD = 16'h4444;
    localparam logic [15:0] P_COR  = 16'h8081;
    localparam logic [15:0] P_RST  = 16'hB5E3;
    localparam logic [15:0] P_RW   = ~(P_RO | P_W1C | P_RSVD);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  lane_en = '0;
    logic [15:0] wdata = '0;
    logic [15:0] hw_set = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        wr_done;
    logic [15:0] wr_value;
    logic [15:0] hw_value;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] model = P_RST;

    always #5 clk = ~clk;

    attr_ctrl_reg #(
        .DATA_W(16), .LANE_W(8),
        .RO_MASK(P_RO), .W1C_MASK(P_W1C), .RSVD_MASK(P_RSVD),
        .COR_MASK(P_COR), .RESET_VAL(P_RST)
    ) dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .lane_en(lane_en),
        .wdata(wdata), .hw_set(hw_set), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_done(wr_done), .wr_value(wr_value), .hw_value(hw_value)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lanes(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // Expected next word, from the per-bit rules.
    function automatic logic [15:0] predict(input logic [15:0] cur, input logic rd, input logic wr,
                                            input logic [1:0] be, input logic [15:0] wd,
                                            input logic [15:0] set);
        logic [15:0] lm;
        logic [15:0] n;
        lm = lanes(be);
        n  = cur;
        for (int i = 0; i < 16; i++) begin
            if (!P_RSVD[i]) begin
                logic v;
                v = cur[i];
                if (rd && lm[i] && P_COR[i]) v = 1'b0;
                if (wr && lm[i] && !P_RO[i]) begin
                    if (P_W1C[i]) begin
                        if (wd[i]) v = 1'b0;
                    end else begin
                        v = wd[i];
                    end
                end
                if (set[i]) v = 1'b1;
                n[i] = v;
            end
        end
        return n;
    endfunction

    // One access: driven at a falling edge, all results checked one rising edge later.
    task automatic access(input logic rd, input logic wr, input logic [1:0] be,
                          input logic [15:0] wd, input logic [15:0] set);
        logic [15:0] lm;
        logic [15:0] exp_rd;
        logic [15:0] nxt;
        logic [15:0] exp_wv;
        lm     = lanes(be);
        exp_rd = rd ? (model & lm & ~P_RSVD) : 16'h0;
        nxt    = predict(model, rd, wr, be, wd, set);
        exp_wv = wr ? (nxt & lm & ~P_RSVD) : 16'h0;
        rd_en = rd; wr_en = wr; lane_en = be; wdata = wd; hw_set = set;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; lane_en = '0; wdata = '0; hw_set = '0;
        chk("R6 rd_valid", {15'b0, rd_valid}, {15'b0, rd});
        chk("R6/R4 rd_data", rd_data, exp_rd);
        chk("R10 wr_done", {15'b0, wr_done}, {15'b0, wr});
        chk("R10/R4 wr_value", wr_value, exp_wv);
        chk("R2 read-only bits", hw_value & P_RO, nxt & P_RO);
        chk("R3 w1c bits", hw_value & P_W1C, nxt & P_W1C);
        chk("R4 reserved bits", hw_value & P_RSVD, P_RST & P_RSVD);
        chk("R5 rw bits", hw_value & P_RW & ~P_COR, nxt & P_RW & ~P_COR);
        chk("R7 cor bits", hw_value & P_COR, nxt & P_COR);
        if ((set & ~P_RSVD) != 16'h0)
            chk("R8 set bits", hw_value & set & ~P_RSVD, set & ~P_RSVD);
        if (rd && wr)
            chk("R9 read+write word", hw_value, nxt);
        if (!rd && !wr && set == 16'h0)
            chk("R11 idle word", hw_value, model);
        model = nxt;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        hw_set = 16'hFFFF;     // must be ignored during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        hw_set = '0;
        chk("R1 reset word", hw_value, P_RST);
        chk("R1 rd_valid low", {15'b0, rd_valid}, 16'h0);
        chk("R1 wr_done low", {15'b0, wr_done}, 16'h0);

        // R5: lane-gated writes to ordinary bits.
        access(1'b0, 1'b1, 2'b01, 16'hFFFF, 16'h0);
        access(1'b0, 1'b1, 2'b10, 16'h0000, 16'h0);
        // R7: narrow read clears only the upper lane's clear-on-read bits.
        access(1'b0, 1'b1, 2'b11, 16'h8080, 16'h0001);
        access(1'b1, 1'b0, 2'b10, 16'h0000, 16'h0);
        chk("R7 lower lane kept", hw_value & 16'h0081, 16'h0081);
        access(1'b1, 1'b0, 2'b01, 16'h0000, 16'h0);
        chk("R7 lower lane cleared", hw_value & 16'h0081, 16'h0000);
        // R9: read and write together; the written one on a clear-on-read bit stays.
        access(1'b1, 1'b1, 2'b01, 16'h0080, 16'h0);
        chk("R9 written cor bit kept", hw_value & 16'h0080, 16'h0080);
        // R8: set wins against a w1c clear in the same cycle.
        access(1'b0, 1'b0, 2'b00, 16'h0000, 16'h0202);
        access(1'b0, 1'b1, 2'b11, 16'h0202, 16'h0002);
        chk("R8 set beats w1c", hw_value & 16'h0202, 16'h0002);
        // R11: idle cycles.
        access(1'b0, 1'b0, 2'b11, 16'hFFFF, 16'h0);
        access(1'b0, 1'b0, 2'b00, 16'h0000, 16'h0);

        // Sweep: set on/off, all lane enables, all strobe pairs, several data patterns.
        for (int s = 0; s < 2; s++) begin
            for (int be = 0; be < 4; be++) begin
                for (int op = 0; op < 4; op++) begin
                    for (int p = 0; p < 6; p++) begin
                        logic [15:0] wd;
                        logic [15:0] st;
                        unique case (p)
                            0: wd = 16'h0000;
                            1: wd = 16'hFFFF;
                            2: wd = 16'hAAAA;
                            3: wd = 16'h5555;
                            4: wd = 16'h1234 * (be + 1) + 16'(op * 77);
                            default: wd = ~model;
                        endcase
                        st = (s == 1) ? ((16'h0101 << p) | 16'(be * 16'h2200)) : 16'h0;
                        access(op[1], op[0], be[1:0], wd, st);
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule